// File: doc/BRIEF.md
# NAND Bad Block Check and Mark Engine

This engine decides whether an erase block of a large-page NAND device has been retired, and retires a block on request. A client presents a block number together with either a check or a mark command. The engine turns the block number into the address of the block's first page. It then issues one single-byte random-access operation at a fixed spare-area column to a downstream NAND operation sequencer, and reports the outcome with a one-cycle done pulse.

The retirement marker is a custom byte value (0x33) kept in the spare area, just past the two spare-area ECC bytes. It is not the factory convention of checking for a non-0xFF byte. A check reads that byte. A mark programs it and then interprets the program status byte that the sequencer returns. Block numbers outside the device are refused at once, and nothing is sent to the sequencer.

Top module: `nbb_engine`

## Requirements
- R1: Every operation issued for block number B addresses page B*64, which is the block's first page. With the default geometry of 2048 blocks of 64 pages, `op_page_o` is 17 bits wide.
- R2: Every issued operation addresses in-page column 2054. Columns 2048 to 2051 hold the main-area ECC and columns 2052 to 2053 hold the spare-area ECC.
- R3: A check (`req_mark`=0) issues a read (`op_write_o`=0). The result is `result_o`=2'b11 (bit 1 valid, bit 0 bad) when the returned byte equals 0x33, and 2'b10 for any other byte.
- R4: A mark (`req_mark`=1) issues a write (`op_write_o`=1) of data byte 0x33. The result is 2'b11 when bit 0 of the returned status byte is 1 (failure), and 2'b10 when that bit is 0 (pass), whatever the other status bits are.
- R5: A request whose block number is 2048 or above never raises `op_valid_o`. In the cycle after acceptance it gives `done_o`=1, `err_o`=1 and `result_o`=2'b00, and `busy_o` stays 0.
- R6: `busy_o` rises in the cycle after a valid request is accepted and falls in the cycle in which `done_o` pulses. Any request presented while `busy_o` is 1 is ignored and produces no operation and no result.
- R7: `done_o` is high for exactly one cycle per accepted request. `result_o` and `err_o` then keep their values until the next request is accepted, which clears both to 0.
- R8: Once `op_valid_o` is raised, it and all operation fields stay unchanged until the sequencer takes the operation with `op_ready_i`. A response with `rsp_valid_i` counts only after the operation has been taken.
- R9: After reset, `busy_o`, `done_o`, `err_o`, `op_valid_o` are 0 and `result_o` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_mark | input | 1 | 0 = check block, 1 = mark block bad |
| req_block | input | 12 | Block number (values of 2048 and above are rejected) |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | {valid, bad} for a check, {valid, fail} for a mark |
| err_o | output | 1 | Block number out of range |
| op_valid_o | output | 1 | Operation offered to the sequencer |
| op_ready_i | input | 1 | Sequencer takes the offered operation |
| op_write_o | output | 1 | 0 = random single-byte read, 1 = random single-byte program |
| op_page_o | output | 17 | Page (row) address |
| op_col_o | output | 12 | In-page column address |
| op_wdata_o | output | 8 | Byte to program |
| rsp_valid_i | input | 1 | Sequencer result available |
| rsp_data_i | input | 8 | Byte read, or program status byte |

## Verification
Two events can coincide. A new client request can arrive in the same cycle in which the sequencer's response completes the current one. Another request can arrive in the very cycle in which `done_o` is high. The bench provokes the first case by driving `req_valid` together with `rsp_valid_i`, and judges that no second operation appears and that the result belongs to the first block. It provokes the second case by presenting a request during the done cycle, and judges that the engine accepts it immediately, clears the old result and offers the new page.

// File: rtl/nbb_pkg.sv
package nbb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } nbb_state_e;

    localparam logic [1:0] RES_NONE = 2'b00;

endpackage

// File: rtl/nbb_req_decode.sv
module nbb_req_decode #(
    parameter int NUM_BLOCKS      = 2048,
    parameter int PAGES_PER_BLOCK = 64,
    parameter int BLK_IN_W        = 12,
    localparam int BLK_W          = $clog2(NUM_BLOCKS),
    localparam int PAGE_SHIFT     = $clog2(PAGES_PER_BLOCK),
    localparam int PAGE_W         = BLK_W + PAGE_SHIFT
) (
    input  logic [BLK_IN_W-1:0] blk_i,
    output logic                in_range_o,
    output logic [PAGE_W-1:0]   page_o
);
    // Range check against the device size, then shift to the first page.
    assign in_range_o = (blk_i < BLK_IN_W'(NUM_BLOCKS));
    assign page_o     = {blk_i[BLK_W-1:0], {PAGE_SHIFT{1'b0}}};

endmodule

// File: rtl/nbb_verdict.sv
module nbb_verdict #(
    parameter logic [7:0] MARK_BYTE = 8'h33
) (
    input  logic       is_mark_i,
    input  logic [7:0] rsp_byte_i,
    output logic       flag_o
);
    // Mark: program status bit 0 set means failure.
    // Check: marker byte present means retired block.
    always_comb begin
        if (is_mark_i) flag_o = rsp_byte_i[0];
        else           flag_o = (rsp_byte_i == MARK_BYTE);
    end

endmodule

// File: rtl/nbb_engine.sv
module nbb_engine
    import nbb_pkg::*;
#(
    parameter int         NUM_BLOCKS      = 2048,
    parameter int         PAGES_PER_BLOCK = 64,
    parameter int         BLK_IN_W        = 12,
    parameter int         COL_W           = 12,
    parameter int         MARK_COL        = 2054,
    parameter logic [7:0] MARK_BYTE       = 8'h33,
    localparam int        PAGE_W          = $clog2(NUM_BLOCKS) + $clog2(PAGES_PER_BLOCK)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_mark,
    input  logic [BLK_IN_W-1:0] req_block,
    output logic                busy_o,
    output logic                done_o,
    output logic [1:0]          result_o,
    output logic                err_o,
    output logic                op_valid_o,
    input  logic                op_ready_i,
    output logic                op_write_o,
    output logic [PAGE_W-1:0]   op_page_o,
    output logic [COL_W-1:0]    op_col_o,
    output logic [7:0]          op_wdata_o,
    input  logic                rsp_valid_i,
    input  logic [7:0]          rsp_data_i
);

    typedef struct packed {
        nbb_state_e          state;
        logic                is_mark;
        logic [PAGE_W-1:0]   page;
        logic                done;
        logic                err;
        logic [1:0]          result;
    } eng_t;

    eng_t cur_q, nxt_d;

    logic              blk_ok;
    logic [PAGE_W-1:0] blk_page;
    logic              verdict;

    nbb_req_decode #(
        .NUM_BLOCKS      (NUM_BLOCKS),
        .PAGES_PER_BLOCK (PAGES_PER_BLOCK),
        .BLK_IN_W        (BLK_IN_W)
    ) decode_i (
        .blk_i      (req_block),
        .in_range_o (blk_ok),
        .page_o     (blk_page)
    );

    nbb_verdict #(
        .MARK_BYTE (MARK_BYTE)
    ) verdict_i (
        .is_mark_i  (cur_q.is_mark),
        .rsp_byte_i (rsp_data_i),
        .flag_o     (verdict)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        case (cur_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    nxt_d.result  = RES_NONE;
                    nxt_d.err     = 1'b0;
                    nxt_d.is_mark = req_mark;
                    nxt_d.page    = blk_page;
                    if (blk_ok) begin
                        nxt_d.state = ST_ISSUE;
                    end else begin
                        nxt_d.done = 1'b1;
                        nxt_d.err  = 1'b1;
                    end
                end
            end
            ST_ISSUE: begin
                if (op_ready_i) nxt_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (rsp_valid_i) begin
                    nxt_d.state  = ST_IDLE;
                    nxt_d.done   = 1'b1;
                    nxt_d.result = {1'b1, verdict};
                end
            end
            default: nxt_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_IDLE, is_mark: 1'b0, page: '0,
                       done: 1'b0, err: 1'b0, result: RES_NONE};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy_o     = (cur_q.state != ST_IDLE);
    assign done_o     = cur_q.done;
    assign result_o   = cur_q.result;
    assign err_o      = cur_q.err;
    assign op_valid_o = (cur_q.state == ST_ISSUE);
    assign op_write_o = cur_q.is_mark;
    assign op_page_o  = cur_q.page;
    assign op_col_o   = COL_W'(MARK_COL);
    assign op_wdata_o = MARK_BYTE;

    AST_OP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_o && !op_ready_i) |=> (op_valid_o && $stable(op_page_o) && $stable(op_write_o))); // R8
    AST_ERR_NO_OP: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!op_valid_o && !busy_o)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o); // R6
    AST_RES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o && !$rose(busy_o)) |-> $stable(result_o)); // R7
    AST_VALID_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> result_o[1]); // R3

endmodule

// File: tb/nbb_engine_tb.sv
`timescale 1ns/1ps
module nbb_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_mark = 1'b0;
    logic [11:0] req_block = '0;
    logic        busy_o, done_o, err_o, op_valid_o, op_write_o;
    logic [1:0]  result_o;
    logic        op_ready_i = 1'b0;
    logic [16:0] op_page_o;
    logic [11:0] op_col_o;
    logic [7:0]  op_wdata_o;
    logic        rsp_valid_i = 1'b0;
    logic [7:0]  rsp_data_i = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    nbb_engine dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_mark(req_mark), .req_block(req_block),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .err_o(err_o),
        .op_valid_o(op_valid_o), .op_ready_i(op_ready_i), .op_write_o(op_write_o),
        .op_page_o(op_page_o), .op_col_o(op_col_o), .op_wdata_o(op_wdata_o),
        .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // {mark, block, response byte, expected result, expected err}
    localparam logic [23:0] VEC [0:8] = '{
        {1'b0, 12'd0,    8'h33, 2'b11, 1'b0},
        {1'b0, 12'd2047, 8'hFF, 2'b10, 1'b0},
        {1'b0, 12'd5,    8'h32, 2'b10, 1'b0},
        {1'b1, 12'd1,    8'h00, 2'b10, 1'b0},
        {1'b1, 12'd2047, 8'h01, 2'b11, 1'b0},
        {1'b1, 12'd100,  8'hFE, 2'b10, 1'b0},
        {1'b0, 12'd2048, 8'h00, 2'b00, 1'b1},
        {1'b1, 12'd4095, 8'h00, 2'b00, 1'b1},
        {1'b0, 12'd3000, 8'h33, 2'b00, 1'b1}
    };

    task automatic send_req(input logic mk, input logic [11:0] blk);
        @(negedge clk);
        req_valid = 1'b1; req_mark = mk; req_block = blk;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Sequencer model for an accepted in-range request; checks the operation.
    task automatic serve(input logic mk, input logic [11:0] blk, input logic [7:0] byt);
        chk("R6 busy after accept", busy_o, 1);
        chk("R1 page", op_page_o, int'(blk) * 64);
        chk("R2 column", op_col_o, 2054);
        chk(mk ? "R4 write op" : "R3 read op", op_write_o, mk);
        if (mk) chk("R4 data byte", op_wdata_o, 8'h33);
        chk("R8 offered", op_valid_o, 1);
        rsp_valid_i = 1'b1; rsp_data_i = 8'h33;  // stray response before take
        @(negedge clk);
        rsp_valid_i = 1'b0;
        chk("R8 held without ready", op_valid_o, 1);
        chk("R8 page stable", op_page_o, int'(blk) * 64);
        chk("R8 no early done", done_o, 0);
        op_ready_i = 1'b1;
        @(negedge clk);
        op_ready_i = 1'b0;
        chk("R8 dropped after take", op_valid_o, 0);
        @(negedge clk);
        rsp_valid_i = 1'b1; rsp_data_i = byt;
        @(negedge clk);
        rsp_valid_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 busy", busy_o, 0);
        chk("R9 done", done_o, 0);
        chk("R9 err", err_o, 0);
        chk("R9 op_valid", op_valid_o, 0);
        chk("R9 result", result_o, 0);
        rst_n = 1'b1;

        for (int i = 0; i < 9; i++) begin
            logic        mk;
            logic [11:0] blk;
            logic [7:0]  byt;
            logic [1:0]  er;
            logic        ee;
            {mk, blk, byt, er, ee} = VEC[i];
            send_req(mk, blk);
            if (ee) begin
                chk("R5 done", done_o, 1);
                chk("R5 err", err_o, 1);
                chk("R5 result", result_o, 0);
                chk("R5 no busy", busy_o, 0);
                chk("R5 no op", op_valid_o, 0);
                @(negedge clk);
                chk("R5 no op later", op_valid_o, 0);
                chk("R7 err held", err_o, 1);
            end else begin
                serve(mk, blk, byt);
                chk(mk ? "R4 result" : "R3 result", result_o, er);
                chk("R7 done", done_o, 1);
                chk("R6 busy falls", busy_o, 0);
                chk("R7 err clear", err_o, 0);
                @(negedge clk);
                chk("R7 done one cycle", done_o, 0);
                chk("R7 result held", result_o, er);
            end
            repeat (2) @(negedge clk);
            chk("R7 result still held", result_o, er);
        end

        // R6: request while busy, and one coinciding with the response.
        send_req(1'b0, 12'd7);
        req_valid = 1'b1; req_mark = 1'b1; req_block = 12'd9;  // during ISSUE
        op_ready_i = 1'b1;
        @(negedge clk);
        op_ready_i = 1'b0;
        rsp_valid_i = 1'b1; rsp_data_i = 8'h33;  // same cycle as req_valid
        @(negedge clk);
        rsp_valid_i = 1'b0;
        req_valid = 1'b0;
        chk("R6 first done", done_o, 1);
        chk("R6 result of first block", result_o, 3);
        @(negedge clk);
        chk("R6 ignored request no op", op_valid_o, 0);
        chk("R6 ignored request no busy", busy_o, 0);

        // Request in the done cycle is accepted.
        send_req(1'b0, 12'd11);
        op_ready_i = 1'b1;
        @(negedge clk);
        op_ready_i = 1'b0;
        rsp_valid_i = 1'b1; rsp_data_i = 8'h00;
        @(negedge clk);
        rsp_valid_i = 1'b0;
        chk("R7 done A", done_o, 1);
        req_valid = 1'b1; req_mark = 1'b1; req_block = 12'd12;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R6 accepted in done cycle", busy_o, 1);
        chk("R7 result cleared", result_o, 0);
        chk("R1 page of new request", op_page_o, 12 * 64);
        chk("R4 write for new request", op_write_o, 1);
        op_ready_i = 1'b1;
        @(negedge clk);
        op_ready_i = 1'b0;
        rsp_valid_i = 1'b1; rsp_data_i = 8'hC1;
        @(negedge clk);
        rsp_valid_i = 1'b0;
        chk("R4 fail status bit0", result_o, 3);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule